// File: doc/BRIEF.md
# Modulo-K Up/Down Loop Counter

This block is the loop-filter stage of a digital phase-locked loop. It runs on a clock at M times the loop center frequency. On each enabled cycle it steps a modulo-K counter up or down, and the phase-detector output bit chooses the direction. When the counter wraps past its top value it raises a one-cycle carry pulse. When it wraps below zero it raises a one-cycle borrow pulse.

Over a long run, carries count as positive pulses and borrows as negative ones. Their net rate is the detector output, mapped to the range ±1, times the clock rate, divided by K. The downstream pulse add/delete stage turns this into a frequency correction.

K is a power of two, chosen at run time by a 4-bit code. The live count is brought out for debug.

Top module: `kfilt_loop_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `count_o` is 0 and both `carry_o` and `borrow_o` are low.
- R2: With `cnt_en` high, `dir_up` high and the count below K-1, the count rises by one at each clock edge and no pulse is issued.
- R3: With `cnt_en` high, `dir_up` low and the count above 0, the count falls by one at each clock edge and no pulse is issued.
- R4: An enabled up step taken at count K-1 loads 0 and sets `carry_o` high for exactly that following cycle.
- R5: An enabled down step taken at count 0 loads K-1 and sets `borrow_o` high for exactly that following cycle.
- R6: `k_code` value c selects K = 2^(c+3) for c from 0 to 14. Code 15 selects K = 2^17, the same modulus as code 14.
- R7: A clock edge at which `k_code` differs from the code the counter last used clears the count to 0. That edge issues no pulse, and the clear wins over an enabled step taken at the same edge.
- R8: An edge with `cnt_en` low leaves the count unchanged and issues no pulse, whatever `dir_up` is.
- R9: `carry_o` and `borrow_o` are never high together. Neither is high in two consecutive cycles.
- R10: With the code held fixed from a count of 0, (carries − borrows)·K + count equals (up steps − down steps) at every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, M times the loop center frequency |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Count enable; low holds the count |
| dir_up | input | 1 | Phase-detector bit: 1 steps up, 0 steps down |
| k_code | input | 4 | Modulus select, K = 2^(code+3), clamped at 2^17 |
| carry_o | output | 1 | One-cycle pulse on an upward wrap |
| borrow_o | output | 1 | One-cycle pulse on a downward wrap |
| count_o | output | 17 | Current count, for debug |

## Verification
Two actions can fall on the same edge: a wrap and a modulus change. The bench brings the count to K-1 with up steps. It then changes `k_code` at the same edge as one more enabled up step. The check expects the count to be 0 and no carry, because the clear takes priority and suppresses the pulse. The opposite direction is covered the same way: at count 0 a down step meets a code change, and the check expects no borrow and a count that stays at 0.

// File: rtl/kfilt_pkg.sv
package kfilt_pkg;

  localparam int unsigned SEL_W   = 4;
  localparam int unsigned LOG_MIN = 3;
  localparam int unsigned LOG_MAX = 17;
  localparam int unsigned CNT_W   = LOG_MAX;

  // action chosen for one clock edge
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DOWN  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  // wrap value (K-1) for a modulus code, clamped at the largest modulus
  function automatic logic [CNT_W-1:0] top_of(input logic [SEL_W-1:0] code);
    int unsigned lg;
    lg = int'(code) + LOG_MIN;
    if (lg > LOG_MAX) lg = LOG_MAX;
    return CNT_W'((64'd1 << lg) - 64'd1);
  endfunction

endpackage

// File: rtl/kfilt_modsel.sv
// Holds the modulus code in use, flags a code change, and decodes the wrap value.
module kfilt_modsel #(
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned CNT_W   = 17,
  parameter int unsigned LOG_MIN = 3,
  parameter int unsigned LOG_MAX = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             chg_o,
  output logic [CNT_W-1:0] top_o
);

  localparam int unsigned LW = 8;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic [LW-1:0]    log_w;

  // next state: take the new code on every edge
  always_comb begin
    sel_d = sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign chg_o = (sel_i != sel_q);

  // log2(K) for the stored code, clamped
  always_comb begin
    log_w = LW'(sel_q) + LW'(LOG_MIN);
    if (log_w > LW'(LOG_MAX)) begin
      log_w = LW'(LOG_MAX);
    end
  end

  // thermometer mask: bit g is set when g lies below log2(K)
  for (genvar g = 0; g < int'(CNT_W); g++) begin : g_mask
    assign top_o[g] = (LW'(g) < log_w);
  end

endmodule

// File: rtl/kfilt_ctrl.sv
// Picks the action for the next edge: a clear on a code change, otherwise a step or a hold.
module kfilt_ctrl
  import kfilt_pkg::*;
(
  input  logic chg_i,
  input  logic en_i,
  input  logic up_i,
  output act_e act_o
);

  always_comb begin
    if (chg_i) begin
      act_o = ACT_CLEAR;
    end else if (en_i) begin
      act_o = up_i ? ACT_UP : ACT_DOWN;
    end else begin
      act_o = ACT_HOLD;
    end
  end

endmodule

// File: rtl/kfilt_core.sv
// Modulo-K count register with registered wrap pulses.
module kfilt_core
  import kfilt_pkg::*;
#(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  act_e         act_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         car_o,
  output logic         bor_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         car_q, car_d;
  logic         bor_q, bor_d;
  logic         cnt_ld;
  logic         at_top;
  logic         at_zero;

  assign at_top  = (cnt_q == top_i);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    car_d = 1'b0;
    bor_d = 1'b0;
    unique case (act_i)
      ACT_CLEAR: cnt_d = '0;
      ACT_UP: begin
        if (at_top) begin
          cnt_d = '0;
          car_d = 1'b1;
        end else begin
          cnt_d = cnt_q + W'(1);
        end
      end
      ACT_DOWN: begin
        if (at_zero) begin
          cnt_d = top_i;
          bor_d = 1'b1;
        end else begin
          cnt_d = cnt_q - W'(1);
        end
      end
      default: cnt_d = cnt_q;
    endcase
  end

  // the count register loads only when an action other than a hold is chosen
  assign cnt_ld = (act_i != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= 1'b0;
      bor_q <= 1'b0;
    end else begin
      car_q <= car_d;
      bor_q <= bor_d;
    end
  end

  assign cnt_o = cnt_q;
  assign car_o = car_q;
  assign bor_o = bor_q;

endmodule

// File: rtl/kfilt_loop_counter.sv
module kfilt_loop_counter
  import kfilt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic [SEL_W-1:0] k_code,
  output logic             carry_o,
  output logic             borrow_o,
  output logic [CNT_W-1:0] count_o
);

  logic             chg;
  logic [CNT_W-1:0] top;
  act_e             act;

  kfilt_modsel #(
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W),
    .LOG_MIN(LOG_MIN),
    .LOG_MAX(LOG_MAX)
  ) u_modsel (
    .clk  (clk),
    .rst_n(rst_n),
    .sel_i(k_code),
    .chg_o(chg),
    .top_o(top)
  );

  kfilt_ctrl u_ctrl (
    .chg_i(chg),
    .en_i (cnt_en),
    .up_i (dir_up),
    .act_o(act)
  );

  kfilt_core #(
    .W(CNT_W)
  ) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .act_i(act),
    .top_i(top),
    .cnt_o(count_o),
    .car_o(carry_o),
    .bor_o(borrow_o)
  );

endmodule

// File: rtl/kfilt_loop_counter_chk.sv
module kfilt_loop_counter_chk
  import kfilt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [SEL_W-1:0] k_code,
  input logic             carry_o,
  input logic             borrow_o,
  input logic [CNT_W-1:0] count_o
);

  // R9
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_o && borrow_o));

  // R9
  carry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> !carry_o);

  // R9
  borrow_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_o |=> !borrow_o);

  // R4
  carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (count_o == '0));

  // R5
  borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_o |-> (count_o == top_of($past(k_code))));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cnt_en) |-> (!carry_o && !borrow_o));

  // R8
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cnt_en) |-> ($stable(count_o) || count_o == '0));

  // R7
  code_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(k_code) != k_code) |=> (count_o == '0 && !carry_o && !borrow_o));

endmodule

bind kfilt_loop_counter kfilt_loop_counter_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .k_code  (k_code),
  .carry_o (carry_o),
  .borrow_o(borrow_o),
  .count_o (count_o)
);

// File: tb/sim_kfilt_loop_counter.sv
`timescale 1ns/1ps
module sim_kfilt_loop_counter;

  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic        dir_up;
  logic [3:0]  k_code;
  logic        carry_o;
  logic        borrow_o;
  logic [16:0] count_o;

  int n_chk  = 0;
  int n_bad  = 0;
  int m_cnt  = 0;
  int m_sel  = 0;
  int m_car  = 0;
  int m_bor  = 0;
  int prev_car = 0;
  int prev_bor = 0;
  int cycles = 0;
  bit done   = 0;

  kfilt_loop_counter u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .dir_up  (dir_up),
    .k_code  (k_code),
    .carry_o (carry_o),
    .borrow_o(borrow_o),
    .count_o (count_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int k_of(input int code);
    int lg;
    lg = code + 3;
    if (lg > 17) lg = 17;
    return 1 << lg;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
        summary();
      end
    end
  end

  // one clock edge: drive at the falling edge, update the model, sample 1 ns after the rising edge
  task automatic step(input bit en, input bit up, input int code, input string req);
    int k;
    @(negedge clk);
    cnt_en = en;
    dir_up = up;
    k_code = 4'(code);
    @(posedge clk);
    #1;
    k = k_of(m_sel);
    m_car = 0;
    m_bor = 0;
    if (code != m_sel) begin
      m_sel = code;
      m_cnt = 0;
    end else if (en) begin
      if (up) begin
        if (m_cnt == k - 1) begin m_cnt = 0; m_car = 1; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_cnt = k - 1; m_bor = 1; end
        else m_cnt = m_cnt - 1;
      end
    end
    n_chk++;
    if (int'(count_o) != m_cnt || int'(carry_o) != m_car || int'(borrow_o) != m_bor) begin
      n_bad++;
      $display("FAIL %s: actual count=%0d carry=%0d borrow=%0d, expected count=%0d carry=%0d borrow=%0d",
               req, count_o, carry_o, borrow_o, m_cnt, m_car, m_bor);
    end
    n_chk++;
    if ((carry_o && borrow_o) || (carry_o && prev_car == 1) || (borrow_o && prev_bor == 1)) begin
      n_bad++;
      $display("FAIL R9: actual carry=%0d borrow=%0d (previous %0d/%0d), expected single non-overlapping pulses",
               carry_o, borrow_o, prev_car, prev_bor);
    end
    prev_car = int'(carry_o);
    prev_bor = int'(borrow_o);
  endtask

  initial begin
    int ups;
    int downs;
    int cars;
    int bors;
    int k;
    rst_n  = 1'b0;
    cnt_en = 1'b0;
    dir_up = 1'b0;
    k_code = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values during reset
    n_chk++;
    if (count_o != '0 || carry_o || borrow_o) begin
      n_bad++;
      $display("FAIL R1: actual count=%0d carry=%0d borrow=%0d, expected 0/0/0", count_o, carry_o, borrow_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 0, "R1");

    // R2, R4: counting up with K=8, through several wraps
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 0, "R2/R4");
    // R3, R5: counting down through several wraps
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, "R3/R5");
    // R8: enable low, direction toggling
    for (int i = 0; i < 10; i++) step(1'b0, 1'(i % 2), 0, "R8");

    // R6, R4, R5: full up and down wraps for each small code
    for (int c = 1; c <= 6; c++) begin
      step(1'b0, 1'b0, c, "R7");
      for (int i = 0; i < k_of(c) + 2; i++) step(1'b1, 1'b1, c, "R6/R4");
      for (int i = 0; i < k_of(c) + 2; i++) step(1'b1, 1'b0, c, "R6/R5");
    end
    // R6: large codes, a borrow to K-1 and a carry back to 0
    for (int c = 7; c <= 15; c++) begin
      step(1'b1, 1'b1, c, "R7");
      step(1'b1, 1'b0, c, "R6/R5");
      step(1'b1, 1'b1, c, "R6/R4");
    end

    // R7: the code changes at the same edge as an upward wrap
    step(1'b0, 1'b0, 0, "R7");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 0, "R2");
    step(1'b1, 1'b1, 1, "R7");
    // R7: the code changes at the same edge as a downward wrap from 0
    step(1'b1, 1'b0, 2, "R7");
    // R7: the code changes while the enable is low
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 2, "R2");
    step(1'b0, 1'b1, 3, "R7");

    // R10: duty pattern with three up steps in every four, K=16
    step(1'b0, 1'b0, 1, "R7");
    ups = 0; downs = 0; cars = 0; bors = 0;
    k = k_of(1);
    for (int i = 0; i < 400; i++) begin
      bit u;
      u = (i % 4) != 3;
      step(1'b1, u, 1, "R10");
      if (u) ups++; else downs++;
      cars += int'(carry_o);
      bors += int'(borrow_o);
      n_chk++;
      if ((cars - bors) * k + int'(count_o) != ups - downs) begin
        n_bad++;
        $display("FAIL R10: actual net=%0d, expected %0d",
                 (cars - bors) * k + int'(count_o), ups - downs);
      end
    end
    // R10: pattern with one up step in every four, stepping from the present count
    ups = 0; downs = 0; cars = 0; bors = 0;
    begin
      int base;
      base = int'(count_o);
      for (int i = 0; i < 400; i++) begin
        bit u;
        u = (i % 4) == 0;
        step(1'b1, u, 1, "R10");
        if (u) ups++; else downs++;
        cars += int'(carry_o);
        bors += int'(borrow_o);
        n_chk++;
        if ((cars - bors) * k + int'(count_o) - base != ups - downs) begin
          n_bad++;
          $display("FAIL R10: actual net=%0d, expected %0d",
                   (cars - bors) * k + int'(count_o) - base, ups - downs);
        end
      end
    end

    done = 1;
    summary();
  end

endmodule